// File: doc/BRIEF.md
# AHB-Lite Burst Request Splitter

This block turns one memory request from a processor core into the address and control phases of an AHB-Lite manager. A request gives a start address, an access size, a direction and a length. The block then drives the bus with a series of packets. Each packet is a single beat, a four-beat incrementing burst, an eight-beat incrementing burst or an eight-beat wrapping burst. It aligns each address to the access size, forces instruction fetches to word size, and honours HREADY wait states. When the final data phase completes, it pulses `done`.

Word requests of any length are split greedily into packets of 8, 4 and 1 beats. An incrementing burst is never allowed to cross a 1 KB boundary. A request marked as a cache linefill is always issued as one eight-beat wrapping burst. That burst starts at the requested (critical) word and wraps inside its 32-byte line. The bus carries no data through this block: write data and read data are handled by the surrounding logic.

Top module: `ahb_burst_splitter`

## Requirements
- R1: HBURST takes only the values 3'b000 (single), 3'b011 (four-beat incrementing), 3'b101 (eight-beat incrementing) and 3'b100 (eight-beat wrapping) whenever HTRANS is not IDLE.
- R2: A word request of N words (`req_size`=2'b10) is split largest-first. While 8 or more words remain, an eight-beat incrementing burst is used. Otherwise, while 4 or more remain, a four-beat incrementing burst is used. The remaining words go out as single transfers. Within an incrementing burst the address rises by 4 per beat.
- R3: HTRANS is 2'b10 (NONSEQ) on the first beat of every packet, 2'b11 (SEQ) on the following beats, and 2'b00 (IDLE) when no beat is offered.
- R4: An incrementing packet that would cross a 1 KB address boundary is replaced by one single transfer. The next packet is then planned from the following address.
- R5: A halfword request (`req_size`=2'b01) is issued with HSIZE 3'b001 and with address bit 0 cleared.
- R6: A word request is issued with HSIZE 3'b010 and with address bits 1:0 cleared.
- R7: A request with `req_fetch` high is issued as a word access (HSIZE 3'b010, word-aligned), whatever `req_size` holds.
- R8: A request with `req_fill` high is issued as exactly eight wrapping beats, whatever `req_len` holds. It starts at the word-aligned request address and steps by 4 modulo the 32-byte line.
- R9: Byte (`req_size`=2'b00) and halfword requests are issued as `req_len` single transfers, with the address stepping by the access size.
- R10: While HREADY is low during an offered beat, HADDR, HTRANS, HBURST and HSIZE hold their values.
- R11: `req_ready` is high only when no request is in progress. `done` is a one-cycle pulse in the cycle after the edge where HREADY completes the data phase of the last beat.
- R12: A `req_len` of zero is treated as one.
- R13: HWRITE equals the request's `req_write` on every beat of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_addr | input | AW | Start byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 or 11 word |
| req_write | input | 1 | 1 write, 0 read |
| req_len | input | LW | Number of transfers (0 means 1) |
| req_fetch | input | 1 | Instruction fetch, forces word size |
| req_fill | input | 1 | Cache linefill, forces one wrapping eight-beat burst |
| hready | input | 1 | Bus ready / data phase completion |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst type |
| hsize | output | 3 | Transfer size |
| haddr | output | AW | Transfer address |
| hwrite | output | 1 | Transfer direction |
| done | output | 1 | Request completed pulse |

## Verification
Some internal faults show at once. A wrong remaining-word count or packet counter shows within one accepted beat, as a burst type or NONSEQ/SEQ marking that differs from the expected beat list. A faulty address stepper or wrap logic shows as a wrong HADDR on the very next SEQ beat. A bad boundary check appears only when a packet starts within 28 bytes below a 1 KB boundary, so such start addresses are aimed at deliberately. The reference model compares every cycle, so a broken hold under HREADY low is seen on the first stalled cycle. A missed final data phase is seen as a `done` that comes one or more cycles off.

// File: rtl/ahb_split_pkg.sv
package ahb_split_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [2:0] {
    BU_SINGLE = 3'b000,
    BU_INCR4  = 3'b011,
    BU_WRAP8  = 3'b100,
    BU_INCR8  = 3'b101
  } burst_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ADDR  = 2'b01,
    ST_LASTD = 2'b10
  } split_st_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

endpackage

// File: rtl/ahb_split_planner.sv
module ahb_split_planner
  import ahb_split_pkg::*;
#(
  parameter int LW         = 8,
  parameter int BOUND_BITS = 10
) (
  input  logic [BOUND_BITS-3:0] word_idx,
  input  logic [LW-1:0]         rem,
  input  logic                  word_mode,
  input  logic                  fill,
  output burst_e                burst,
  output logic [3:0]            beats
);
  localparam int IW = BOUND_BITS - 2;

  // fits[0]: four-beat span stays inside the boundary, fits[1]: eight-beat span
  logic [1:0] fits;

  for (genvar g = 0; g < 2; g++) begin : g_span
    localparam int SPAN = 4 << g;
    logic [IW:0] last_idx;
    assign last_idx = {1'b0, word_idx} + (IW+1)'(SPAN - 1);
    assign fits[g]  = ~last_idx[IW];
  end

  always_comb begin
    burst = BU_SINGLE;
    beats = 4'd1;
    if (fill) begin
      burst = BU_WRAP8;
      beats = 4'd8;
    end else if (word_mode) begin
      if (rem >= LW'(8)) begin
        if (fits[1]) begin
          burst = BU_INCR8;
          beats = 4'd8;
        end
      end else if (rem >= LW'(4)) begin
        if (fits[0]) begin
          burst = BU_INCR4;
          beats = 4'd4;
        end
      end
    end
  end

endmodule

// File: rtl/ahb_split_addr.sv
module ahb_split_addr #(
  parameter int AW        = 32,
  parameter int LINE_BITS = 5
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          wrap,
  output logic [AW-1:0] nxt
);
  localparam int WB = LINE_BITS - 2;

  logic [AW-1:0] inc_addr;
  logic [AW-1:0] wrap_addr;
  logic [WB-1:0] word_in_line;

  assign inc_addr     = addr + (AW'(1) << size);
  assign word_in_line = addr[LINE_BITS-1:2] + WB'(1);
  assign wrap_addr    = {addr[AW-1:LINE_BITS], word_in_line, 2'b00};
  assign nxt          = wrap ? wrap_addr : inc_addr;

endmodule

// File: rtl/ahb_burst_splitter.sv
module ahb_burst_splitter
  import ahb_split_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 8,
  parameter int BOUND_BITS = 10,
  parameter int LINE_BITS  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [LW-1:0] req_len,
  input  logic          req_fetch,
  input  logic          req_fill,
  input  logic          hready,
  output logic [1:0]    htrans,
  output logic [2:0]    hburst,
  output logic [2:0]    hsize,
  output logic [AW-1:0] haddr,
  output logic          hwrite,
  output logic          done
);
  localparam int LINE_WORDS = 1 << (LINE_BITS - 2);

  split_st_e     st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] rem_q, rem_d;
  logic [3:0]    pkt_q, pkt_d;
  burst_e        burst_q, burst_d;
  logic [1:0]    size_q;
  logic          write_q, fill_q, first_q, first_d, done_q, done_d;
  logic          ld_en, adv_en;

  // request decode
  logic [1:0]    req_sz_eff;
  logic [AW-1:0] req_aligned;
  logic [LW-1:0] req_n;

  always_comb begin
    req_sz_eff = req_size;
    if (req_fetch || req_fill || req_size == 2'b11) req_sz_eff = SZ_WORD;
    case (req_sz_eff)
      SZ_HALF: req_aligned = {req_addr[AW-1:1], 1'b0};
      SZ_WORD: req_aligned = {req_addr[AW-1:2], 2'b00};
      default: req_aligned = req_addr;
    endcase
    if (req_fill)               req_n = LW'(LINE_WORDS);
    else if (req_len == '0)     req_n = LW'(1);
    else                        req_n = req_len;
  end

  // address stepping
  logic [AW-1:0] nxt_addr;
  ahb_split_addr #(.AW(AW), .LINE_BITS(LINE_BITS)) u_addr (
    .addr (addr_q),
    .size (size_q),
    .wrap (fill_q),
    .nxt  (nxt_addr)
  );

  // packet planning, for the request start or for the next packet
  logic [AW-1:0] plan_addr;
  logic [LW-1:0] plan_rem;
  logic          plan_word, plan_fill;
  burst_e        plan_burst;
  logic [3:0]    plan_beats;

  always_comb begin
    if (st_q == ST_IDLE) begin
      plan_addr = req_aligned;
      plan_rem  = req_n;
      plan_word = (req_sz_eff == SZ_WORD);
      plan_fill = req_fill;
    end else begin
      plan_addr = nxt_addr;
      plan_rem  = rem_q - LW'(1);
      plan_word = (size_q == SZ_WORD);
      plan_fill = fill_q;
    end
  end

  ahb_split_planner #(.LW(LW), .BOUND_BITS(BOUND_BITS)) u_plan (
    .word_idx  (plan_addr[BOUND_BITS-1:2]),
    .rem       (plan_rem),
    .word_mode (plan_word),
    .fill      (plan_fill),
    .burst     (plan_burst),
    .beats     (plan_beats)
  );

  // control next state
  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    ld_en  = 1'b0;
    adv_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_en = 1'b1;
          st_d  = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (hready) begin
          adv_en = 1'b1;
          if (rem_q == LW'(1)) st_d = ST_LASTD;
        end
      end
      ST_LASTD: begin
        if (hready) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // datapath next state
  logic new_pkt;
  always_comb begin
    new_pkt = ld_en || (pkt_q == 4'd1);
    addr_d  = ld_en ? req_aligned : nxt_addr;
    rem_d   = ld_en ? req_n : (rem_q - LW'(1));
    pkt_d   = new_pkt ? plan_beats : (pkt_q - 4'd1);
    burst_d = new_pkt ? plan_burst : burst_q;
    first_d = new_pkt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
      pkt_q   <= '0;
      burst_q <= BU_SINGLE;
      first_q <= 1'b0;
      size_q  <= SZ_BYTE;
      write_q <= 1'b0;
      fill_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (ld_en || adv_en) begin
        addr_q  <= addr_d;
        rem_q   <= rem_d;
        pkt_q   <= pkt_d;
        burst_q <= burst_d;
        first_q <= first_d;
      end
      if (ld_en) begin
        size_q  <= req_sz_eff;
        write_q <= req_write;
        fill_q  <= req_fill;
      end
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign htrans    = (st_q == ST_ADDR) ? (first_q ? TR_NONSEQ : TR_SEQ) : TR_IDLE;
  assign hburst    = burst_q;
  assign hsize     = {1'b0, size_q};
  assign haddr     = addr_q;
  assign hwrite    = write_q;
  assign done      = done_q;

  // R1
  burst_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != TR_IDLE) |-> (hburst == BU_SINGLE || hburst == BU_INCR4 ||
                             hburst == BU_INCR8  || hburst == BU_WRAP8));

  // R2
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == TR_SEQ && hburst != BU_WRAP8 && $past(hready))
      |-> (haddr == $past(haddr) + AW'(4)));

  // R4
  no_kb_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == TR_NONSEQ && hburst == BU_INCR8) |-> (haddr[BOUND_BITS-1:2] <= {(BOUND_BITS-2){1'b1}} - 7));

  // R6
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != TR_IDLE && hsize == 3'b010) |-> (haddr[1:0] == 2'b00));

  // R5
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != TR_IDLE && hsize == 3'b001) |-> (haddr[0] == 1'b0));

  // R8
  wrap_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == TR_SEQ && hburst == BU_WRAP8 && $past(hready))
      |-> (haddr[AW-1:LINE_BITS] == $past(haddr[AW-1:LINE_BITS])));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != TR_IDLE && !hready)
      |=> ($stable(haddr) && $stable(htrans) && $stable(hburst) && $stable(hsize)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_ahb_burst_splitter.sv
module sim_ahb_burst_splitter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_fetch, req_fill;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [7:0]  req_len;
  logic        hready;
  logic [1:0]  htrans;
  logic [2:0]  hburst, hsize;
  logic [31:0] haddr;
  logic        hwrite, done;

  always #5 clk = ~clk;

  ahb_burst_splitter u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_len(req_len), .req_fetch(req_fetch), .req_fill(req_fill),
    .hready(hready), .htrans(htrans), .hburst(hburst), .hsize(hsize),
    .haddr(haddr), .hwrite(hwrite), .done(done)
  );

  typedef struct {
    logic [31:0] a;
    logic [1:0]  t;
    logic [2:0]  b;
  } beat_t;

  beat_t       bq[$];
  int          checks = 0;
  int          errors = 0;
  int          ph = 0;        // 0 idle, 1 beats pending, 2 last data phase
  logic        done_exp = 1'b0;
  logic [2:0]  exp_size;
  logic        exp_write;
  int          rdy_mode = 0;
  string       tag = "R3";
  bit          finished = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic void push(input logic [31:0] a, input logic [1:0] t, input logic [2:0] b);
    beat_t x;
    x.a = a; x.t = t; x.b = b;
    bq.push_back(x);
  endfunction

  function automatic void model(input logic [31:0] addr, input logic [1:0] sz,
                                input bit fetch, input bit fill, input int len);
    int es, n, rem, k, idx;
    logic [31:0] a, base;
    logic [2:0] b;
    es = (fetch || fill || sz == 2'b11) ? 2 : int'(sz);
    a = addr & ~((32'd1 << es) - 32'd1);
    n = (len == 0) ? 1 : len;
    exp_size = 3'(es);
    if (fill) begin
      base = a & ~32'h1f;
      for (int i = 0; i < 8; i++)
        push(base + 32'(((int'(a[4:2]) + i) % 8) * 4), (i == 0) ? 2'b10 : 2'b11, 3'b100);
    end else if (es != 2) begin
      for (int i = 0; i < n; i++) push(a + 32'(i << es), 2'b10, 3'b000);
    end else begin
      rem = n;
      while (rem > 0) begin
        idx = int'(a[9:2]);
        if (rem >= 8 && idx + 7 <= 255)      begin k = 8; b = 3'b101; end
        else if (rem >= 8)                   begin k = 1; b = 3'b000; end
        else if (rem >= 4 && idx + 3 <= 255) begin k = 4; b = 3'b011; end
        else                                 begin k = 1; b = 3'b000; end
        for (int i = 0; i < k; i++) push(a + 32'(i * 4), (i == 0) ? 2'b10 : 2'b11, b);
        a = a + 32'(k * 4);
        rem = rem - k;
      end
    end
  endfunction

  task automatic step(input bit issue);
    logic [1:0] et;
    @(negedge clk);
    et = (bq.size() > 0) ? bq[0].t : 2'b00;
    chk({tag, " R3 htrans"}, 32'(htrans), 32'(et));
    if (bq.size() > 0) begin
      chk({tag, " haddr"}, haddr, bq[0].a);
      chk({tag, " R1 hburst"}, 32'(hburst), 32'(bq[0].b));
      chk({tag, " hsize"}, 32'(hsize), 32'(exp_size));
      chk("R13 hwrite", 32'(hwrite), 32'(exp_write));
    end
    chk("R11 done", 32'(done), 32'(done_exp));
    chk("R11 req_ready", 32'(req_ready), 32'(ph == 0));
    case (rdy_mode)
      0:       hready = 1'b1;
      1:       hready = ($urandom % 4) != 0;
      default: hready = ($urandom % 3) == 0;
    endcase
    done_exp = 1'b0;
    if (ph == 2 && hready) begin
      ph = 0;
      done_exp = 1'b1;
    end else if (ph == 1 && hready) begin
      void'(bq.pop_front());
      if (bq.size() == 0) ph = 2;
    end
    req_valid = issue;
  endtask

  task automatic do_req(input string t, input int mode, input logic [31:0] addr,
                        input logic [1:0] sz, input bit wr, input int len,
                        input bit fetch, input bit fill);
    while (ph != 0) step(0);
    tag = t;
    rdy_mode = mode;
    req_addr = addr; req_size = sz; req_write = wr; req_len = 8'(len);
    req_fetch = fetch; req_fill = fill;
    step(1);
    exp_write = wr;
    model(addr, sz, fetch, fill, len);
    ph = 1;
    while (ph != 0) step(0);
    step(0);
    step(0);
  endtask

  initial begin
    rst_n = 1'b0; hready = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_write = 1'b0; req_len = '0; req_fetch = 1'b0; req_fill = 1'b0;
    exp_size = 3'd2; exp_write = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset htrans", 32'(htrans), 32'd0);
    chk("R11 reset done", 32'(done), 32'd0);
    chk("R11 reset req_ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    step(0);
    do_req("R2 R13 single write", 0, 32'h0000_1004, 2'b10, 1'b1, 1, 1'b0, 1'b0);
    do_req("R2 len13", 0, 32'h0000_2000, 2'b10, 1'b0, 13, 1'b0, 1'b0);
    do_req("R2 R6 len3 unaligned", 0, 32'h0000_3003, 2'b10, 1'b1, 3, 1'b0, 1'b0);
    do_req("R4 kb8", 0, 32'h0000_03F0, 2'b10, 1'b0, 8, 1'b0, 1'b0);
    do_req("R4 kb4", 0, 32'h0000_07F8, 2'b10, 1'b1, 4, 1'b0, 1'b0);
    do_req("R8 fill", 0, 32'h0000_4014, 2'b10, 1'b0, 3, 1'b0, 1'b1);
    do_req("R9 byte", 0, 32'h0000_5001, 2'b00, 1'b1, 3, 1'b0, 1'b0);
    do_req("R5 R9 half", 0, 32'h0000_6003, 2'b01, 1'b0, 4, 1'b0, 1'b0);
    do_req("R7 fetch", 0, 32'h0000_7002, 2'b00, 1'b0, 4, 1'b1, 1'b0);
    do_req("R12 len0", 0, 32'h0000_8008, 2'b10, 1'b0, 0, 1'b0, 1'b0);
    do_req("R10 R2 stall len20", 1, 32'h0000_9000, 2'b10, 1'b1, 20, 1'b0, 1'b0);
    do_req("R10 R8 stall fill", 2, 32'h0000_A01C, 2'b10, 1'b0, 0, 1'b0, 1'b1);
    do_req("R10 R4 stall kb", 2, 32'h0000_0BE4, 2'b11, 1'b0, 12, 1'b0, 1'b0);
    do_req("R10 R9 stall half", 1, 32'h0000_0C02, 2'b01, 1'b1, 5, 1'b0, 1'b0);
    for (int r = 0; r < 20; r++)
      do_req("R2 R10 rand", 1 + (r % 2), $urandom & 32'h0000_0FFF, 2'(r % 4), r[0],
             $urandom % 30, (r % 7) == 3, (r % 5) == 4);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule